// File: doc/BRIEF.md
# Converter Parallel Control Interface

This block is the digital side of a combined 8-bit analog-to-digital and digital-to-analog converter that has an input multiplexer. A host drives an 8-bit parallel bus and strobes it with an active-low write enable. Two active-low chip selects steer each write. The control select sends the byte to one of two control registers. The converter select sends the byte to the DAC input latch. A write to the range/channel register launches a conversion. The block emits a one-cycle start pulse and then waits for a conversion-done input from the analog model, which is outside this block.

A read strobe taken low under the converter select places the ADC result on the bus through an output-enable. Bit 6 of the reference-select register turns on digital loopback. With loopback on, the rising edge of the read strobe also copies the ADC result into the DAC latch, so that both converters can be tested in one pass. All strobes, selects and the bus are asynchronous to the block clock. They pass through a two-stage synchronizer, and edges are detected after it.

Top module: `conv_bus_ctrl`

## Requirements
- R1: After reset the range/channel register, the reference-select register and the DAC code all read 0x00. Code 0x00 is the midpoint output in two's complement. The channel field is 0, loopback is off, data_valid, conv_start and bus_oe are 0, and bus_out is 0x00.
- R2: On a rising edge of wr_n with ctl_sel_n low and bus bits [1:0] not 00, the byte is stored in range_reg. conv_start is high for exactly one cycle. The register update and the pulse both appear on the third rising clock edge after wr_n rises.
- R3: On a rising edge of wr_n with ctl_sel_n low and bus bits [1:0] = 00, the byte is stored in ref_reg. No conv_start pulse is issued and range_reg is unchanged.
- R4: On a rising edge of wr_n with cnv_sel_n low and ctl_sel_n high, the byte is stored in dac_code and no conversion starts. When both selects are low, the control write takes effect and dac_code is unchanged.
- R5: A rising edge of wr_n with both selects high changes no register and issues no start pulse.
- R6: While rd_n and cnv_sel_n are both low, bus_oe is 1 and bus_out equals adc_result, from the third rising clock edge after the strobe falls. At all other times bus_oe is 0 and bus_out is 0x00.
- R7: When ref_reg bit 6 is 1, a rising edge of rd_n with cnv_sel_n low copies adc_result into dac_code on the third clock edge after it. When bit 6 is 0, a read leaves dac_code unchanged.
- R8: data_valid is cleared together with each conv_start pulse. It is set on the clock edge that samples conv_done high. If a start and conv_done fall on the same edge, the start wins.
- R9: chan_sel equals range_reg bits [4:2], and loopback_en equals ref_reg bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_sel_n | input | 1 | Active-low select for the control registers |
| cnv_sel_n | input | 1 | Active-low select for the converter data path |
| wr_n | input | 1 | Active-low write strobe; data is taken on its rising edge |
| rd_n | input | 1 | Active-low read strobe |
| bus_in | input | 8 | Parallel data from the host |
| bus_out | output | 8 | Read data toward the host |
| bus_oe | output | 1 | Output enable for bus_out; low means the bus is released |
| adc_result | input | 8 | Result from the behavioural ADC |
| conv_done | input | 1 | Conversion-finished pulse from the behavioural ADC |
| conv_start | output | 1 | One-cycle conversion start pulse |
| data_valid | output | 1 | A conversion has completed since the last start |
| range_reg | output | 8 | Range/channel register |
| ref_reg | output | 8 | Reference-select register |
| dac_code | output | 8 | DAC input latch |
| chan_sel | output | 3 | Selected input channel |
| loopback_en | output | 1 | Digital loopback enabled |

## Verification
Strobe-driven results take three clock edges: two synchronizer stages and one edge-detect register. Register contents, conv_start and bus_oe are therefore due on the third rising edge after the strobe changes. The bench drives its inputs on falling edges and samples exactly three falling edges later. It also confirms that the outputs have not yet changed one edge earlier. data_valid responds to conv_done on the very next edge and is sampled one falling edge after the pulse is applied. In random operations, the start pulses are counted over a six-cycle window, and the full register state is compared only after every pipeline stage has settled.

// File: rtl/conv_bus_pkg.sv
package conv_bus_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int LB_BIT   = 6;
  localparam int CHAN_LSB = 2;
  localparam int CHAN_W   = 3;
  localparam int SYNC_N   = 2;
  localparam int CTRL_W   = 4;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/conv_sync.sv
module conv_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/conv_reg_file.sv
module conv_reg_file
  import conv_bus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_rise,
  input  logic  rd_rise,
  input  logic  ctl_sel,
  input  logic  cnv_sel,
  input  byte_t bus_byte,
  input  byte_t adc_result,
  input  logic  conv_done,
  output byte_t range_q,
  output byte_t ref_q,
  output byte_t dac_q,
  output logic  conv_start,
  output logic  data_valid
);
  byte_t range_d, ref_d, dac_d;
  logic  start_d, dv_d;
  logic  ctl_wr, ref_hit, range_wr, ref_wr, dac_wr, lb_copy;

  always_comb begin
    ctl_wr   = wr_rise & ctl_sel;
    ref_hit  = (bus_byte[ADDR_W-1:0] == '0);
    range_wr = ctl_wr & ~ref_hit;
    ref_wr   = ctl_wr & ref_hit;
    dac_wr   = wr_rise & cnv_sel & ~ctl_sel;
    lb_copy  = rd_rise & cnv_sel & ref_q[LB_BIT];

    range_d = range_q;
    ref_d   = ref_q;
    dac_d   = dac_q;
    if (range_wr) range_d = bus_byte;
    if (ref_wr)   ref_d   = bus_byte;
    if (dac_wr)        dac_d = bus_byte;
    else if (lb_copy)  dac_d = adc_result;

    start_d = range_wr;
    if (range_wr)       dv_d = 1'b0;
    else if (conv_done) dv_d = 1'b1;
    else                dv_d = data_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      range_q    <= '0;
      ref_q      <= '0;
      dac_q      <= '0;
      conv_start <= 1'b0;
      data_valid <= 1'b0;
    end else begin
      range_q    <= range_d;
      ref_q      <= ref_d;
      dac_q      <= dac_d;
      conv_start <= start_d;
      data_valid <= dv_d;
    end
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R3
  ref_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_q != $past(ref_q)) |-> !conv_start);
  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !data_valid);
  // R8
  dv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(conv_done));
  // R7
  dac_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_q != $past(dac_q)) |-> $past(wr_rise || rd_rise));
endmodule

// File: rtl/conv_rd_path.sv
module conv_rd_path
  import conv_bus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_act,
  input  byte_t adc_result,
  output byte_t bus_out,
  output logic  bus_oe
);
  byte_t out_d;
  logic  oe_d;

  always_comb begin
    oe_d  = rd_act;
    out_d = rd_act ? adc_result : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
    end else begin
      bus_oe  <= oe_d;
      bus_out <= out_d;
    end
  end

  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0));
endmodule

// File: rtl/conv_bus_ctrl.sv
module conv_bus_ctrl
  import conv_bus_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_sel_n,
  input  logic                cnv_sel_n,
  input  logic                wr_n,
  input  logic                rd_n,
  input  logic [DATA_W-1:0]   bus_in,
  output logic [DATA_W-1:0]   bus_out,
  output logic                bus_oe,
  input  logic [DATA_W-1:0]   adc_result,
  input  logic                conv_done,
  output logic                conv_start,
  output logic                data_valid,
  output logic [DATA_W-1:0]   range_reg,
  output logic [DATA_W-1:0]   ref_reg,
  output logic [DATA_W-1:0]   dac_code,
  output logic [CHAN_W-1:0]   chan_sel,
  output logic                loopback_en
);
  localparam int PIPE_W = CTRL_W + DATA_W;
  localparam logic [PIPE_W-1:0] PIPE_RST = {{CTRL_W{1'b1}}, {DATA_W{1'b0}}};

  logic              rst_sync_n;
  logic [PIPE_W-1:0] pipe_d, pipe_q;
  logic              ctl_s_n, cnv_s_n, wr_s_n, rd_s_n;
  byte_t             bus_s;
  logic              wr_prev, rd_prev, wr_prev_d, rd_prev_d;
  logic              wr_rise, rd_rise, rd_act;

  conv_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  assign pipe_d = {ctl_sel_n, cnv_sel_n, wr_n, rd_n, bus_in};

  conv_sync #(.W(PIPE_W), .STAGES(SYNC_N), .RST_VAL(PIPE_RST)) u_in_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pipe_d), .q(pipe_q)
  );

  assign {ctl_s_n, cnv_s_n, wr_s_n, rd_s_n, bus_s} = pipe_q;

  always_comb begin
    wr_prev_d = wr_s_n;
    rd_prev_d = rd_s_n;
    wr_rise   = wr_s_n & ~wr_prev;
    rd_rise   = rd_s_n & ~rd_prev;
    rd_act    = ~rd_s_n & ~cnv_s_n;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_prev <= 1'b1;
      rd_prev <= 1'b1;
    end else begin
      wr_prev <= wr_prev_d;
      rd_prev <= rd_prev_d;
    end
  end

  conv_reg_file u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_rise(wr_rise), .rd_rise(rd_rise),
    .ctl_sel(~ctl_s_n), .cnv_sel(~cnv_s_n),
    .bus_byte(bus_s), .adc_result(adc_result), .conv_done(conv_done),
    .range_q(range_reg), .ref_q(ref_reg), .dac_q(dac_code),
    .conv_start(conv_start), .data_valid(data_valid)
  );

  conv_rd_path u_rd (
    .clk(clk), .rst_n(rst_sync_n), .rd_act(rd_act),
    .adc_result(adc_result), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  assign chan_sel    = range_reg[CHAN_LSB +: CHAN_W];
  assign loopback_en = ref_reg[LB_BIT];

  // R5
  no_sel_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_rise && ctl_s_n && cnv_s_n) |=>
      ($stable(range_reg) && $stable(ref_reg) && $stable(dac_code) && !conv_start));
  // R4
  ctl_priority_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_rise && !ctl_s_n && !rd_rise) |=> $stable(dac_code));
endmodule

// File: tb/conv_bus_ctrl_tb.sv
`timescale 1ns/1ps
module conv_bus_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n, ctl_sel_n, cnv_sel_n, wr_n, rd_n, conv_done;
  logic [7:0] bus_in, adc_result;
  logic [7:0] bus_out, range_reg, ref_reg, dac_code;
  logic       bus_oe, conv_start, data_valid, loopback_en;
  logic [2:0] chan_sel;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [7:0] m_range, m_ref, m_dac;
  logic       m_dv;

  always #4 clk = ~clk;

  conv_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_sel_n(ctl_sel_n), .cnv_sel_n(cnv_sel_n),
    .wr_n(wr_n), .rd_n(rd_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .adc_result(adc_result), .conv_done(conv_done), .conv_start(conv_start),
    .data_valid(data_valid), .range_reg(range_reg), .ref_reg(ref_reg),
    .dac_code(dac_code), .chan_sel(chan_sel), .loopback_en(loopback_en)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [2:0] exp_chan(input logic [7:0] r);
    return r[4:2];
  endfunction

  function automatic logic is_range(input logic [7:0] b);
    return b[1:0] != 2'b00;
  endfunction

  task automatic check_state(input string req);
    chk(req, "range_reg", range_reg, m_range);
    chk(req, "ref_reg", ref_reg, m_ref);
    chk(req, "dac_code", dac_code, m_dac);
    chk("R9", "chan_sel", chan_sel, exp_chan(m_range));
    chk("R9", "loopback_en", loopback_en, m_ref[6]);
    chk("R8", "data_valid", data_valid, m_dv);
  endtask

  // drives a write strobe; reports start pulses seen over six cycles
  task automatic do_write(input logic sc, input logic sv, input logic [7:0] b,
                          output int starts, output int first_at);
    @(negedge clk);
    ctl_sel_n = ~sc; cnv_sel_n = ~sv; bus_in = b;
    @(negedge clk); wr_n = 1'b0;
    step(2);
    wr_n = 1'b1;
    starts = 0; first_at = 0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (conv_start) begin
        starts++;
        if (first_at == 0) first_at = k;
      end
    end
    ctl_sel_n = 1'b1; cnv_sel_n = 1'b1; bus_in = 8'($urandom);
    step(2);
    if (sc) begin
      if (is_range(b)) begin m_range = b; m_dv = 1'b0; end
      else m_ref = b;
    end else if (sv) m_dac = b;
  endtask

  task automatic do_read(input logic sv, input logic [7:0] a);
    @(negedge clk);
    cnv_sel_n = ~sv; adc_result = a; rd_n = 1'b0;
    step(2);
    chk("R6", "bus_oe early", bus_oe, 1'b0);
    step(1);
    chk("R6", "bus_oe", bus_oe, sv);
    chk("R6", "bus_out", bus_out, sv ? a : 8'h00);
    step(1);
    rd_n = 1'b1;
    step(6);
    chk("R6", "bus_oe after", bus_oe, 1'b0);
    cnv_sel_n = 1'b1;
    step(2);
    if (sv && m_ref[6]) m_dac = a;
    adc_result = 8'($urandom);
  endtask

  task automatic pulse_done();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
    m_dv = 1'b1;
    chk("R8", "data_valid after done", data_valid, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int st, fa;
    void'($urandom(32'h5eed_0c17));
    rst_n = 1'b0; ctl_sel_n = 1'b1; cnv_sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    conv_done = 1'b0; bus_in = 8'h00; adc_result = 8'h00;
    m_range = 8'h00; m_ref = 8'h00; m_dac = 8'h00; m_dv = 1'b0;
    step(4);
    rst_n = 1'b1;
    step(5);
    // R1 reset state
    check_state("R1");
    chk("R1", "bus_oe", bus_oe, 1'b0);
    chk("R1", "bus_out", bus_out, 8'h00);
    chk("R1", "conv_start", conv_start, 1'b0);

    // R2 exact timing of a range write
    do_write(1'b1, 1'b0, 8'b1011_0101, st, fa);
    chk("R2", "start count", st, 1);
    chk("R2", "start cycle", fa, 3);
    check_state("R2");

    // R8 done then a start with done on the same edge
    pulse_done();
    check_state("R8");
    @(negedge clk);
    ctl_sel_n = 1'b0; bus_in = 8'h0E;
    @(negedge clk); wr_n = 1'b0;
    step(2); wr_n = 1'b1;
    step(2); conv_done = 1'b1;
    step(1); conv_done = 1'b0;
    chk("R8", "start wins start", conv_start, 1'b1);
    chk("R8", "start wins dv", data_valid, 1'b0);
    ctl_sel_n = 1'b1; step(4);
    m_range = 8'h0E; m_dv = 1'b0;
    check_state("R8");

    // R3 reference write with loopback bit set
    do_write(1'b1, 1'b0, 8'h40, st, fa);
    chk("R3", "no start", st, 0);
    check_state("R3");

    // R4 DAC write and select priority
    do_write(1'b0, 1'b1, 8'hA7, st, fa);
    chk("R4", "no start", st, 0);
    check_state("R4");
    do_write(1'b1, 1'b1, 8'h3D, st, fa);
    chk("R4", "both selects start", st, 1);
    check_state("R4");

    // R5 write with no select
    do_write(1'b0, 1'b0, 8'hFF, st, fa);
    chk("R5", "no start", st, 0);
    check_state("R5");

    // R7 loopback copy, then without select, then disabled
    do_read(1'b1, 8'h5C);
    check_state("R7");
    do_read(1'b0, 8'h11);
    check_state("R7");
    do_write(1'b1, 1'b0, 8'h00, st, fa);
    do_read(1'b1, 8'h99);
    check_state("R7");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [7:0] b;
      op = int'($urandom % 6);
      b  = 8'($urandom);
      case (op)
        0: begin
          do_write(1'b1, 1'b0, b, st, fa);
          chk(is_range(b) ? "R2" : "R3", "start count", st, is_range(b) ? 1 : 0);
          check_state(is_range(b) ? "R2" : "R3");
        end
        1: begin
          do_write(1'b0, 1'b1, b, st, fa);
          chk("R4", "start count", st, 0);
          check_state("R4");
        end
        2: begin do_read(1'b1, b); check_state("R7"); end
        3: begin do_read(1'b0, b); check_state("R6"); end
        4: begin pulse_done(); check_state("R8"); end
        default: begin
          do_write(1'b0, 1'b0, b, st, fa);
          chk("R5", "start count", st, 0);
          check_state("R5");
        end
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule